// File: doc/BRIEF.md
# SONET Transport Overhead Byte Source Selector

This block assembles the transport overhead of an STS-12 frame one byte per clock. Every overhead byte arrives on the parallel bus together with the byte that the serial overhead port delivered for the same slot and with a precomputed B1 parity value. For each slot the block chooses one of three sources: the parallel byte, the serial byte, or a value it produces itself (framing patterns, the computed B1, or zero). The chosen byte leaves on a registered output one clock later.

The block counts slot positions itself. A start-of-frame strobe marks the first framing byte of STS#1. After that strobe each valid byte moves the position forward: the STS-1 index changes fastest, then the overhead column, then the row. There are 9 rows, 3 columns and 12 interleaved STS-1s, so a frame has 324 overhead bytes, and after the last one the position returns to the first slot. Some slots follow fixed rules. Framing bytes are always regenerated, pointer bytes and J0/B2 always pass through, and B1 has its own handling. Four control bits each switch one overhead group, as a whole across all twelve STS-1s, between transparent and serial insert.

Top module: `toh_overhead_inserter`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` is 0 and `out_byte` is 0x00.
- R2: Each valid input byte yields exactly one output byte on `out_valid`, one clock later, whatever its source. While `in_valid` is low, `out_valid` is low and `out_byte` holds its last value.
- R3: A valid byte with `in_sof` high is slot row 1, column 1, STS#1. Each following valid byte advances the STS index (1..12), then the column (1..3), then the row (1..9). After row 9, column 3, STS#12 the position returns to row 1, column 1, STS#1. An `in_sof` in the middle of a frame re-anchors the position. Cycles with `in_valid` low do not advance it.
- R4: Row 1 column 1 (A1) always outputs 0xF6 and row 1 column 2 (A2) always outputs 0x28, for all STS-1s, whatever the serial byte and control bits are.
- R5: Row 2 column 1 of STS#1 (B1) outputs `b1_calc`.
- R6: Row 2 column 1 of STS#2..STS#12 outputs 0x00.
- R7: All of row 4 (H1, H2, H3) outputs the parallel byte, whatever the control bits are.
- R8: Row 1 column 3 (J0) and row 5 column 1 (B2) output the parallel byte, whatever the control bits are.
- R9: `grp_ins[0]` controls row 5 columns 2–3 (K1/K2). A value of 1 outputs the serial byte and 0 outputs the parallel byte.
- R10: `grp_ins[1]` controls row 9 columns 1–2 (S1/M0). A value of 1 selects serial and 0 selects parallel.
- R11: `grp_ins[2]` controls row 2 columns 2–3 (E1/F1) and row 9 column 3 (E2). A value of 1 selects serial and 0 selects parallel.
- R12: `grp_ins[3]` controls rows 3, 6, 7 and 8 (D1–D12). A value of 1 selects serial and 0 selects parallel.
- R13: After reset, valid bytes before the first `in_sof` pass the parallel byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An overhead byte is present on this cycle |
| in_sof | input | 1 | This byte is row 1, column 1 of STS#1 |
| par_byte | input | 8 | Byte from the parallel input bus |
| ser_byte | input | 8 | Byte from the serial overhead port for the same slot |
| b1_calc | input | 8 | Recomputed B1 parity for STS#1 |
| grp_ins | input | 4 | Group insert control: bit0 K1/K2, bit1 S1/M0, bit2 E1/F1/E2, bit3 D1–D12; 1 = serial |
| out_valid | output | 1 | Output byte valid |
| out_byte | output | 8 | Selected overhead byte |

## Verification
The wrap from row 9, column 3, STS#12 back to the framing slot is hard to reach from the ports. It happens only after 324 counted valid bytes with no new start strobe, and any miscount shows up only in the next frame. The stimulus therefore streams whole frames with idle gaps placed inside them. It sends one frame with no start strobe so that the framing bytes depend on the wrap alone. It also re-anchors the position with a start strobe in the middle of a frame. The control bits and data patterns are chosen so that the serial and parallel bytes always differ, which makes every source choice visible at the output.

// File: rtl/toh_ins_pkg.sv
// Shared definitions for the overhead byte source selector.
// Assumes the standard 9-row by 3-column transport overhead layout.
package toh_ins_pkg;

    // Number of software-controlled overhead groups.
    localparam int NUM_GRP = 4;

    // Group indices; each is the bit position in the control vector.
    localparam int GRP_KK  = 0;   // K1/K2
    localparam int GRP_SM  = 1;   // S1/M0
    localparam int GRP_ORD = 2;   // E1/F1/E2
    localparam int GRP_DCC = 3;   // D1..D12

    // Source rule attached to a slot.
    typedef enum logic [3:0] {
        SLOT_FRM_A1  = 4'd0,
        SLOT_FRM_A2  = 4'd1,
        SLOT_B1_CALC = 4'd2,
        SLOT_ZERO    = 4'd3,
        SLOT_PAR     = 4'd4,
        SLOT_GRP_KK  = 4'd5,
        SLOT_GRP_SM  = 4'd6,
        SLOT_GRP_ORD = 4'd7,
        SLOT_GRP_DCC = 4'd8
    } slot_kind_e;

    // Map a group index to its slot kind.
    function automatic slot_kind_e grp_kind(input int g);
        case (g)
            GRP_KK:  return SLOT_GRP_KK;
            GRP_SM:  return SLOT_GRP_SM;
            GRP_ORD: return SLOT_GRP_ORD;
            default: return SLOT_GRP_DCC;
        endcase
    endfunction

endpackage

// File: rtl/toh_pos_tracker.sv
// Tracks the overhead slot position (row, column, STS index) of the current
// input byte. A start-of-frame strobe forces the origin for that byte; every
// valid byte afterwards advances STS fastest, then column, then row, wrapping
// at the frame end. Before the first strobe the position is marked unlocked.
// Assumes in_sof is only meaningful together with in_valid.
module toh_pos_tracker #(
    parameter int NUM_STS  = 12,
    parameter int NUM_ROWS = 9,
    parameter int NUM_COLS = 3,
    parameter int STS_W    = 4,
    parameter int ROW_W    = 4,
    parameter int COL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    output logic [ROW_W-1:0] cur_row,
    output logic [COL_W-1:0] cur_col,
    output logic [STS_W-1:0] cur_sts,
    output logic             cur_locked
);

    localparam logic [STS_W-1:0] STS_LAST = STS_W'(NUM_STS - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_ROWS - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(NUM_COLS - 1);

    logic [ROW_W-1:0] nxt_row_q;
    logic [COL_W-1:0] nxt_col_q;
    logic [STS_W-1:0] nxt_sts_q;
    logic             locked_q;

    logic [ROW_W-1:0] adv_row;
    logic [COL_W-1:0] adv_col;
    logic [STS_W-1:0] adv_sts;

    // Position of the byte on the bus: origin on a strobe, else the stored one.
    always_comb begin
        if (in_sof) begin
            cur_row = '0;
            cur_col = '0;
            cur_sts = '0;
        end else begin
            cur_row = nxt_row_q;
            cur_col = nxt_col_q;
            cur_sts = nxt_sts_q;
        end
        cur_locked = in_sof | locked_q;
    end

    // Successor slot of the current position, with column and row carries.
    always_comb begin
        adv_row = cur_row;
        adv_col = cur_col;
        adv_sts = cur_sts + STS_W'(1);
        if (cur_sts == STS_LAST) begin
            adv_sts = '0;
            adv_col = cur_col + COL_W'(1);
            if (cur_col == COL_LAST) begin
                adv_col = '0;
                adv_row = (cur_row == ROW_LAST) ? '0 : cur_row + ROW_W'(1);
            end
        end
    end

    // Store the slot expected next; gaps leave it unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_row_q <= '0;
            nxt_col_q <= '0;
            nxt_sts_q <= '0;
            locked_q  <= 1'b0;
        end else if (in_valid && cur_locked) begin
            nxt_row_q <= adv_row;
            nxt_col_q <= adv_col;
            nxt_sts_q <= adv_sts;
            locked_q  <= 1'b1;
        end
    end

endmodule

// File: rtl/toh_slot_classifier.sv
// Decodes a slot position into the source rule for that byte. Fixed rules
// cover framing, B1, pointer, J0 and B2 slots; the remaining slots belong to
// one of four switchable groups. An unlocked position is always transparent.
// Assumes the 9x3 overhead layout; STS index 0 is STS#1.
module toh_slot_classifier
    import toh_ins_pkg::*;
#(
    parameter int STS_W = 4,
    parameter int ROW_W = 4,
    parameter int COL_W = 2
) (
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic [STS_W-1:0] sts,
    input  logic             locked,
    output slot_kind_e       kind
);

    // Row/column table of source rules.
    always_comb begin
        int r;
        int c;
        r = int'(row);
        c = int'(col);
        kind = SLOT_PAR;
        if (locked) begin
            case (r)
                0: begin
                    case (c)
                        0:       kind = SLOT_FRM_A1;
                        1:       kind = SLOT_FRM_A2;
                        default: kind = SLOT_PAR;       // J0
                    endcase
                end
                1: begin
                    if (c == 0)
                        kind = (sts == '0) ? SLOT_B1_CALC : SLOT_ZERO;
                    else
                        kind = SLOT_GRP_ORD;            // E1, F1
                end
                2, 5, 6, 7: kind = SLOT_GRP_DCC;        // D1..D12
                3:          kind = SLOT_PAR;            // H1..H3
                4: begin
                    if (c == 0)
                        kind = SLOT_PAR;                // B2
                    else
                        kind = SLOT_GRP_KK;             // K1, K2
                end
                8: begin
                    if (c == 2)
                        kind = SLOT_GRP_ORD;            // E2
                    else
                        kind = SLOT_GRP_SM;             // S1, M0
                end
                default: kind = SLOT_PAR;
            endcase
        end
    end

endmodule

// File: rtl/toh_src_mux.sv
// Chooses the output byte from the slot rule and the group control bits and
// registers it, giving a fixed one-clock latency for every source. The byte
// register holds while no valid input is present.
module toh_src_mux
    import toh_ins_pkg::*;
#(
    parameter int                BYTE_W = 8,
    parameter logic [BYTE_W-1:0] A1_VAL = 8'hF6,
    parameter logic [BYTE_W-1:0] A2_VAL = 8'h28
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  slot_kind_e         kind,
    input  logic [NUM_GRP-1:0] grp_ins,
    input  logic [BYTE_W-1:0]  par_byte,
    input  logic [BYTE_W-1:0]  ser_byte,
    input  logic [BYTE_W-1:0]  b1_calc,
    output logic               out_valid,
    output logic [BYTE_W-1:0]  out_byte
);

    logic [NUM_GRP-1:0] grp_hit;
    logic               take_serial;
    logic [BYTE_W-1:0]  sel_byte;

    // One comparator per group: the slot belongs to it and it is set to insert.
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign grp_hit[g] = (kind == grp_kind(g)) && grp_ins[g];
    end

    assign take_serial = |grp_hit;

    // Byte selection for the current slot.
    always_comb begin
        case (kind)
            SLOT_FRM_A1:  sel_byte = A1_VAL;
            SLOT_FRM_A2:  sel_byte = A2_VAL;
            SLOT_B1_CALC: sel_byte = b1_calc;
            SLOT_ZERO:    sel_byte = '0;
            default:      sel_byte = take_serial ? ser_byte : par_byte;
        endcase
    end

    // Output register; the byte holds across idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_byte <= sel_byte;
        end
    end

endmodule

// File: rtl/toh_overhead_inserter.sv
// Top level of the STS-12 overhead byte source selector. Tracks the slot
// position, classifies the slot and registers the selected byte.
// Assumes one overhead byte per valid cycle and B1 computed upstream.
module toh_overhead_inserter
    import toh_ins_pkg::*;
#(
    parameter int                BYTE_W   = 8,
    parameter int                NUM_STS  = 12,
    parameter int                NUM_ROWS = 9,
    parameter int                NUM_COLS = 3,
    parameter logic [BYTE_W-1:0] A1_VAL   = 8'hF6,
    parameter logic [BYTE_W-1:0] A2_VAL   = 8'h28
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic [BYTE_W-1:0]  par_byte,
    input  logic [BYTE_W-1:0]  ser_byte,
    input  logic [BYTE_W-1:0]  b1_calc,
    input  logic [NUM_GRP-1:0] grp_ins,
    output logic               out_valid,
    output logic [BYTE_W-1:0]  out_byte
);

    localparam int STS_W = (NUM_STS  > 1) ? $clog2(NUM_STS)  : 1;
    localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
    localparam int COL_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1;

    logic [ROW_W-1:0] pos_row;
    logic [COL_W-1:0] pos_col;
    logic [STS_W-1:0] pos_sts;
    logic             pos_locked;
    slot_kind_e       slot_kind;

    toh_pos_tracker #(
        .NUM_STS (NUM_STS),
        .NUM_ROWS(NUM_ROWS),
        .NUM_COLS(NUM_COLS),
        .STS_W   (STS_W),
        .ROW_W   (ROW_W),
        .COL_W   (COL_W)
    ) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .cur_row   (pos_row),
        .cur_col   (pos_col),
        .cur_sts   (pos_sts),
        .cur_locked(pos_locked)
    );

    toh_slot_classifier #(
        .STS_W(STS_W),
        .ROW_W(ROW_W),
        .COL_W(COL_W)
    ) u_cls (
        .row   (pos_row),
        .col   (pos_col),
        .sts   (pos_sts),
        .locked(pos_locked),
        .kind  (slot_kind)
    );

    toh_src_mux #(
        .BYTE_W(BYTE_W),
        .A1_VAL(A1_VAL),
        .A2_VAL(A2_VAL)
    ) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .kind     (slot_kind),
        .grp_ins  (grp_ins),
        .par_byte (par_byte),
        .ser_byte (ser_byte),
        .b1_calc  (b1_calc),
        .out_valid(out_valid),
        .out_byte (out_byte)
    );

endmodule

// File: rtl/toh_ins_checker.sv
// Property checker for the overhead byte source selector, bound to the top.
// Observes the ports and the position decoded by the tracker.
module toh_ins_checker #(
    parameter int                BYTE_W = 8,
    parameter int                ROW_W  = 4,
    parameter int                COL_W  = 2,
    parameter int                STS_W  = 4,
    parameter logic [BYTE_W-1:0] A1_VAL = 8'hF6,
    parameter logic [BYTE_W-1:0] A2_VAL = 8'h28
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_sof,
    input logic [BYTE_W-1:0] par_byte,
    input logic [BYTE_W-1:0] b1_calc,
    input logic              out_valid,
    input logic [BYTE_W-1:0] out_byte,
    input logic [ROW_W-1:0]  pos_row,
    input logic [COL_W-1:0]  pos_col,
    input logic [STS_W-1:0]  pos_sts,
    input logic              pos_locked
);

    logic b1_slot;
    assign b1_slot = in_valid && pos_locked && pos_row == ROW_W'(1) && pos_col == COL_W'(0);

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !out_valid && out_byte == '0); // R1
    AST_VALID_LAG:   assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
    AST_IDLE_LAG:    assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
    AST_IDLE_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_byte)); // R2
    AST_SOF_A1:      assert property (@(posedge clk) disable iff (!rst_n) in_valid && in_sof |=> out_byte == A1_VAL); // R4
    AST_A2_FIXED:    assert property (@(posedge clk) disable iff (!rst_n)
                         in_valid && pos_locked && pos_row == ROW_W'(0) && pos_col == COL_W'(1) |=> out_byte == A2_VAL); // R4
    AST_B1_CALC:     assert property (@(posedge clk) disable iff (!rst_n)
                         b1_slot && pos_sts == STS_W'(0) |=> out_byte == $past(b1_calc)); // R5
    AST_B1_ZERO:     assert property (@(posedge clk) disable iff (!rst_n)
                         b1_slot && pos_sts != STS_W'(0) |=> out_byte == '0); // R6
    AST_PTR_PASS:    assert property (@(posedge clk) disable iff (!rst_n)
                         in_valid && pos_locked && pos_row == ROW_W'(3) |=> out_byte == $past(par_byte)); // R7
    AST_UNLOCK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
                         in_valid && !pos_locked |=> out_byte == $past(par_byte)); // R13

endmodule

bind toh_overhead_inserter toh_ins_checker #(
    .BYTE_W(BYTE_W),
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .STS_W (STS_W),
    .A1_VAL(A1_VAL),
    .A2_VAL(A2_VAL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .par_byte  (par_byte),
    .b1_calc   (b1_calc),
    .out_valid (out_valid),
    .out_byte  (out_byte),
    .pos_row   (pos_row),
    .pos_col   (pos_col),
    .pos_sts   (pos_sts),
    .pos_locked(pos_locked)
);

// File: tb/tb_toh_overhead_inserter.sv
// Scoreboard bench: the driver predicts each output byte from the
// requirements and queues it; the monitor pops and compares.
module tb_toh_overhead_inserter;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_sof = 1'b0;
    logic [7:0] par_byte = '0;
    logic [7:0] ser_byte = '0;
    logic [7:0] b1_calc = '0;
    logic [3:0] grp_ins = '0;
    logic       out_valid;
    logic [7:0] out_byte;

    int tests_run = 0;
    int tests_failed = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    // Bench-side position model (R3)
    int  m_row = 0, m_col = 0, m_sts = 0;
    bit  m_lock = 1'b0;
    int  seq = 0;
    bit  wrap_tag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    toh_overhead_inserter dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .par_byte(par_byte), .ser_byte(ser_byte), .b1_calc(b1_calc),
        .grp_ins(grp_ins), .out_valid(out_valid), .out_byte(out_byte)
    );

    function automatic logic [7:0] predict(input int r, input int c, input int s,
                                           input bit lk, input logic [7:0] p,
                                           input logic [7:0] sr, input logic [7:0] b,
                                           input logic [3:0] cfg, output string tag);
        if (!lk) begin tag = "R13"; return p; end
        case (r)
            0: begin
                if (c == 0) begin tag = "R4"; return 8'hF6; end
                if (c == 1) begin tag = "R4"; return 8'h28; end
                tag = "R8"; return p;
            end
            1: begin
                if (c == 0) begin
                    if (s == 0) begin tag = "R5"; return b; end
                    tag = "R6"; return 8'h00;
                end
                tag = "R11"; return cfg[2] ? sr : p;
            end
            2, 5, 6, 7: begin tag = "R12"; return cfg[3] ? sr : p; end
            3: begin tag = "R7"; return p; end
            4: begin
                if (c == 0) begin tag = "R8"; return p; end
                tag = "R9"; return cfg[0] ? sr : p;
            end
            default: begin
                if (c == 2) begin tag = "R11"; return cfg[2] ? sr : p; end
                tag = "R10"; return cfg[1] ? sr : p;
            end
        endcase
    endfunction

    task automatic send_byte(input bit sof, input logic [3:0] cfg);
        logic [7:0] p, sr, b, e;
        string tag;
        @(negedge clk);
        seq++;
        p  = {1'b0, 7'(seq * 7 + 3)};
        sr = {1'b1, 7'(seq * 13 + 5)};
        b  = 8'(seq * 29 + 17) | 8'h01;
        in_valid = 1'b1; in_sof = sof; par_byte = p; ser_byte = sr;
        b1_calc = b; grp_ins = cfg;
        if (sof) begin m_row = 0; m_col = 0; m_sts = 0; m_lock = 1'b1; end
        e = predict(m_row, m_col, m_sts, m_lock, p, sr, b, cfg, tag);
        if (wrap_tag) tag = {"R3/", tag};
        exp_q.push_back(e);
        tag_q.push_back({"R2/", tag});
        if (m_lock) begin
            m_sts++;
            if (m_sts == 12) begin
                m_sts = 0; m_col++;
                if (m_col == 3) begin m_col = 0; m_row = (m_row == 8) ? 0 : m_row + 1; end
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_sof = 1'b0;
            par_byte = 8'hA5 ^ 8'(i); ser_byte = 8'h3C ^ 8'(i);
        end
    endtask

    task automatic send_frame(input bit sof, input logic [3:0] cfg, input int gap_every);
        for (int i = 0; i < 324; i++) begin
            send_byte(sof && i == 0, cfg);
            if (gap_every > 0 && (i % gap_every) == gap_every - 1) idle(2);
        end
    endtask

    // Monitor: compare every valid output with the queued prediction (R2)
    always @(negedge clk) begin
        if (rst_n && !done && out_valid) begin
            tests_run++;
            if (exp_q.size() == 0) begin
                tests_failed++;
                $display("FAIL R2 unexpected output: actual %02h expected none", out_byte);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (out_byte !== e) begin
                    tests_failed++;
                    $display("FAIL %s actual %02h expected %02h", t, out_byte, e);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            done = 1'b1;
            tests_run++; tests_failed++;
            $display("FAIL watchdog expired: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        tests_run++;
        if (out_valid !== 1'b0 || out_byte !== 8'h00) begin
            tests_failed++;
            $display("FAIL R1 reset: actual %b/%02h expected 0/00", out_valid, out_byte);
        end
        @(negedge clk); rst_n = 1'b1;
        tests_run++;
        if (out_valid !== 1'b0 || out_byte !== 8'h00) begin
            tests_failed++;
            $display("FAIL R1 after release: actual %b/%02h expected 0/00", out_valid, out_byte);
        end
        // R13: bytes before first start strobe are transparent
        for (int i = 0; i < 5; i++) send_byte(1'b0, 4'hF);
        idle(3);
        // Frame with all groups transparent, gaps inside (R2, R3)
        send_frame(1'b1, 4'h0, 50);
        // Frame with no strobe: position must wrap (R3)
        wrap_tag = 1'b1;
        send_frame(1'b0, 4'hF, 37);
        wrap_tag = 1'b0;
        send_frame(1'b1, 4'h5, 0);
        // Mid-frame re-anchor (R3)
        for (int i = 0; i < 100; i++) send_byte(1'b0, 4'hA);
        send_frame(1'b1, 4'hA, 0);
        send_frame(1'b1, 4'h3, 11);
        idle(4);
        // Everything predicted must have appeared (R2)
        tests_run++;
        if (exp_q.size() != 0) begin
            tests_failed++;
            $display("FAIL R2 missing outputs: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule